// File: doc/BRIEF.md
# Converter Enable and Clock Gate Controller

This block governs two on-chip converters from one register write port. Each converter owns a control register holding an enable bit and a configuration field. While the enable bit is clear, the converter's clock enable output stays low. The configuration field may only be changed while the converter is disabled. Both converters start disabled after reset, so software can set them up safely before turning them on.

A shared settling timer starts counting when the power-good input rises. A converter's clock enable cannot rise until the timer has run its full count, which is derived from the clock frequency and the required analog precharge time. An enable bit written earlier is held, and it takes effect as soon as the timer expires. Each converter has a command path that passes commands through while its clock runs. While the clock is gated, arriving commands are acknowledged and discarded, and a saturating per-converter counter records each discarded command.

Top module: `conv_enable_ctrl`

## Requirements
- R1: After reset every clock enable, configuration field, error flag and drop counter is zero.
- R2: A register write to converter k (write select = k) stores bit 0 of the write data as k's enable bit. Bits CFG_W:1 hold the configuration. The clock enable reflects the stored bit from the cycle after the write edge, provided the timer has expired.
- R3: The clock enable of both converters stays low until power-good has been high for SETTLE cycles in a row. SETTLE is CLK_KHZ*SETTLE_US/1000. A low power-good cycle restarts the count.
- R4: An enable bit written before the timer expires is retained, and the clock enable rises on the cycle in which the timer completes.
- R5: A write to a disabled converter updates its configuration field.
- R6: A write to an enabled converter that carries a different configuration leaves the configuration unchanged and sets that converter's sticky error flag. The enable bit in the same write is still applied, and the flag clears only on reset.
- R7: A write to an enabled converter whose configuration equals the stored value is accepted without raising the error flag.
- R8: While a converter's clock enable is low, its command input is acknowledged (ready high) and no command is presented at its output. Each such command increments the drop counter on the next edge.
- R9: While a converter's clock enable is high, the output valid and data follow the input and the input ready follows the output ready. The drop counter does not change.
- R10: The drop counter saturates at its all-ones value.
- R11: A write to one converter leaves the other converter's configuration, enable and error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Analog supply is up; starts the settling timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W | Converter index of the write |
| wr_data_i | input | CFG_W+1 | Bit 0 enable, bits CFG_W:1 configuration |
| cmd_in_valid_i | input | NCONV | Command valid from the sender, per converter |
| cmd_in_data_i | input | NCONV*CMD_W | Command payload, per converter |
| cmd_in_ready_o | output | NCONV | Command accepted or discarded |
| cmd_out_valid_o | output | NCONV | Command presented to the converter |
| cmd_out_data_o | output | NCONV*CMD_W | Command payload toward the converter |
| cmd_out_ready_i | input | NCONV | Converter can accept a command |
| conv_clk_en_o | output | NCONV | Clock enable for each converter's gate |
| cfg_o | output | NCONV*CFG_W | Stored configuration per converter |
| cfg_err_o | output | NCONV | Sticky blocked-write flag per converter |
| drop_cnt_o | output | NCONV*CNT_W | Saturating discarded-command count |

## Verification
Two functions can collide in one cycle: a register write that turns a converter on, and a command that arrives for that converter. The bench drives both on the same edge. It expects the command to be discarded and counted, because the gate opens only after the edge. It then expects the next command to pass through untouched. A second collision comes from the settling timer expiring while an enable is pending. The bench checks the clock enable in the cycle before expiry and in the expiry cycle. It also checks that the count restarts after power-good drops for one cycle.

// File: rtl/cec_pkg.sv
package cec_pkg;
  // settling count in clock cycles for a given clock (kHz) and delay (us)
  function automatic longint unsigned settle_cycles(input longint unsigned khz,
                                                    input longint unsigned us);
    longint unsigned c;
    c = (khz * us) / 1000;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/cec_rst_sync.sv
module cec_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cec_settle_timer.sv
module cec_settle_timer #(
  parameter longint unsigned TERM = 800000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic settled_o
);
  localparam int CW = $clog2(TERM + 1);
  localparam logic [CW-1:0] TERM_C = CW'(TERM);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pwr_good_i)          cnt_d = '0;
    else if (cnt_q != TERM_C) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign settled_o = (cnt_q == TERM_C);
endmodule

// File: rtl/cec_conv_slot.sv
module cec_conv_slot #(
  parameter int CFG_W = 8,
  parameter int CMD_W = 16,
  parameter int CNT_W = 8,
  parameter int SEL_W = 1,
  parameter int IDX   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             settled_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CFG_W:0]   wr_data_i,
  input  logic             cmd_in_valid_i,
  input  logic [CMD_W-1:0] cmd_in_data_i,
  output logic             cmd_in_ready_o,
  output logic             cmd_out_valid_o,
  output logic [CMD_W-1:0] cmd_out_data_o,
  input  logic             cmd_out_ready_i,
  output logic             clk_en_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             err_o,
  output logic [CNT_W-1:0] drop_cnt_o
);
  localparam logic [SEL_W-1:0] MY_SEL  = SEL_W'(IDX);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_q, en_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_hit, gate_open, drop;

  assign wr_hit    = wr_en_i && (wr_sel_i == MY_SEL);
  assign gate_open = en_q && settled_i;
  assign drop      = cmd_in_valid_i && !gate_open;

  // control register next state
  always_comb begin
    en_d  = en_q;
    cfg_d = cfg_q;
    err_d = err_q;
    if (wr_hit) begin
      en_d = wr_data_i[0];
      if (!en_q)                              cfg_d = wr_data_i[CFG_W:1];
      else if (wr_data_i[CFG_W:1] != cfg_q)   err_d = 1'b1;
    end
  end

  // discarded-command counter next state
  always_comb begin
    cnt_d = cnt_q;
    if (drop && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cfg_q <= '0;
      err_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cfg_q <= cfg_d;
      err_q <= err_d;
      cnt_q <= cnt_d;
    end
  end

  assign cmd_out_valid_o = gate_open && cmd_in_valid_i;
  assign cmd_out_data_o  = gate_open ? cmd_in_data_i : '0;
  assign cmd_in_ready_o  = gate_open ? cmd_out_ready_i : 1'b1;
  assign clk_en_o        = gate_open;
  assign cfg_o           = cfg_q;
  assign err_o           = err_q;
  assign drop_cnt_o      = cnt_q;
endmodule

// File: rtl/conv_enable_ctrl.sv
module conv_enable_ctrl #(
  parameter int NCONV     = 2,
  parameter int CFG_W     = 8,
  parameter int CMD_W     = 16,
  parameter int CNT_W     = 8,
  parameter int CLK_KHZ   = 100000,
  parameter int SETTLE_US = 8000,
  localparam int SEL_W    = (NCONV > 1) ? $clog2(NCONV) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pwr_good_i,
  input  logic                   wr_en_i,
  input  logic [SEL_W-1:0]       wr_sel_i,
  input  logic [CFG_W:0]         wr_data_i,
  input  logic [NCONV-1:0]       cmd_in_valid_i,
  input  logic [NCONV*CMD_W-1:0] cmd_in_data_i,
  output logic [NCONV-1:0]       cmd_in_ready_o,
  output logic [NCONV-1:0]       cmd_out_valid_o,
  output logic [NCONV*CMD_W-1:0] cmd_out_data_o,
  input  logic [NCONV-1:0]       cmd_out_ready_i,
  output logic [NCONV-1:0]       conv_clk_en_o,
  output logic [NCONV*CFG_W-1:0] cfg_o,
  output logic [NCONV-1:0]       cfg_err_o,
  output logic [NCONV*CNT_W-1:0] drop_cnt_o
);
  localparam longint unsigned SETTLE = cec_pkg::settle_cycles(CLK_KHZ, SETTLE_US);

  logic rst_ns;
  logic settled;

  cec_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_ns)
  );

  cec_settle_timer #(.TERM(SETTLE)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ns),
    .pwr_good_i(pwr_good_i),
    .settled_o (settled)
  );

  for (genvar k = 0; k < NCONV; k++) begin : g_slot
    cec_conv_slot #(
      .CFG_W(CFG_W), .CMD_W(CMD_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .IDX(k)
    ) u_slot (
      .clk_i          (clk_i),
      .rst_ni         (rst_ns),
      .settled_i      (settled),
      .wr_en_i        (wr_en_i),
      .wr_sel_i       (wr_sel_i),
      .wr_data_i      (wr_data_i),
      .cmd_in_valid_i (cmd_in_valid_i[k]),
      .cmd_in_data_i  (cmd_in_data_i[k*CMD_W +: CMD_W]),
      .cmd_in_ready_o (cmd_in_ready_o[k]),
      .cmd_out_valid_o(cmd_out_valid_o[k]),
      .cmd_out_data_o (cmd_out_data_o[k*CMD_W +: CMD_W]),
      .cmd_out_ready_i(cmd_out_ready_i[k]),
      .clk_en_o       (conv_clk_en_o[k]),
      .cfg_o          (cfg_o[k*CFG_W +: CFG_W]),
      .err_o          (cfg_err_o[k]),
      .drop_cnt_o     (drop_cnt_o[k*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/cec_checker.sv
module cec_checker #(
  parameter int NCONV = 2,
  parameter int CFG_W = 8,
  parameter int CNT_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   pwr_good_i,
  input logic [NCONV-1:0]       cmd_in_valid_i,
  input logic [NCONV-1:0]       cmd_in_ready_o,
  input logic [NCONV-1:0]       cmd_out_valid_o,
  input logic [NCONV-1:0]       conv_clk_en_o,
  input logic [NCONV*CFG_W-1:0] cfg_o,
  input logic [NCONV-1:0]       cfg_err_o,
  input logic [NCONV*CNT_W-1:0] drop_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar k = 0; k < NCONV; k++) begin : g_chk
    // R8: a gated converter acknowledges and presents nothing
    a_r8_gated_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !conv_clk_en_o[k] |-> (cmd_in_ready_o[k] && !cmd_out_valid_o[k]));

    // R8: each discarded command is counted on the next edge
    a_r8_drop_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_in_valid_i[k] && !conv_clk_en_o[k] && drop_cnt_o[k*CNT_W +: CNT_W] != CNT_MAX)
      |=> drop_cnt_o[k*CNT_W +: CNT_W] == $past(drop_cnt_o[k*CNT_W +: CNT_W]) + 1'b1);

    // R6: configuration cannot move while the converter runs
    a_r6_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_clk_en_o[k] |=> $stable(cfg_o[k*CFG_W +: CFG_W]));

    // R6: the error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o[k] |=> cfg_err_o[k]);

    // R10: the counter never wraps or falls
    a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> drop_cnt_o[k*CNT_W +: CNT_W] >= $past(drop_cnt_o[k*CNT_W +: CNT_W]));

    // R3: power-good low closes the gate on the following cycle
    a_r3_pg_low_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_good_i |=> !conv_clk_en_o[k]);
  end
endmodule

bind conv_enable_ctrl cec_checker #(
  .NCONV(NCONV), .CFG_W(CFG_W), .CNT_W(CNT_W)
) u_cec_checker (.*);

// File: tb/test_conv_enable_ctrl.sv
module test_conv_enable_ctrl;
  localparam int N = 2, CW = 4, DW = 8, NW = 4;
  localparam int SETTLE = 10; // 1000 kHz * 10 us

  logic clk = 1'b0;
  logic rst_n, pg, wr_en, wr_sel;
  logic [CW:0] wr_data;
  logic [N-1:0] in_v, out_r;
  logic [N*DW-1:0] in_d;
  wire  [N-1:0] in_r, out_v, clk_en, err;
  wire  [N*DW-1:0] out_d;
  wire  [N*CW-1:0] cfg;
  wire  [N*NW-1:0] cnt;

  int nchk = 0, nfail = 0;
  logic [CW-1:0] m_cfg [N];
  logic          m_en  [N];
  logic          m_err [N];
  int            m_cnt [N];

  always #2 clk = ~clk;

  conv_enable_ctrl #(
    .NCONV(N), .CFG_W(CW), .CMD_W(DW), .CNT_W(NW), .CLK_KHZ(1000), .SETTLE_US(SETTLE)
  ) i_conv_enable_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cmd_in_valid_i(in_v), .cmd_in_data_i(in_d),
    .cmd_in_ready_o(in_r), .cmd_out_valid_o(out_v), .cmd_out_data_o(out_d),
    .cmd_out_ready_i(out_r), .conv_clk_en_o(clk_en), .cfg_o(cfg),
    .cfg_err_o(err), .drop_cnt_o(cnt)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input int c, input bit e);
    wr_en = 1'b1; wr_sel = s[0]; wr_data = {c[CW-1:0], e};
    @(negedge clk);
    wr_en = 1'b0;
    if (m_en[s] && m_cfg[s] != c[CW-1:0]) m_err[s] = 1'b1;
    else if (!m_en[s]) m_cfg[s] = c[CW-1:0];
    m_en[s] = e;
  endtask

  task automatic check_state(input string tag, input bit settled);
    for (int s = 0; s < N; s++) begin
      chk(cfg[s*CW +: CW] == m_cfg[s], {tag, " cfg"}, int'(cfg[s*CW +: CW]), int'(m_cfg[s]));
      chk(err[s] == m_err[s], {tag, " err"}, int'(err[s]), int'(m_err[s]));
      chk(clk_en[s] == (m_en[s] & settled), {tag, " clk_en"}, int'(clk_en[s]),
          int'(m_en[s] & settled));
    end
  endtask

  initial begin
    #(4 * 100000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    rst_n = 1'b0; pg = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    in_v = '0; in_d = '0; out_r = '1;
    for (int s = 0; s < N; s++) begin
      m_cfg[s] = '0; m_en[s] = 1'b0; m_err[s] = 1'b0; m_cnt[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(clk_en == 0 && cfg == 0 && err == 0 && cnt == 0, "R1 reset", int'(clk_en), 0);

    // R4: enable requested before power-good, remembered; R3 held low
    wr(0, 5, 1'b1);
    check_state("R5 R4 pre-settle", 1'b0);
    repeat (20) @(negedge clk);
    chk(clk_en[0] == 1'b0, "R3 pg low", int'(clk_en[0]), 0);
    pg = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    chk(clk_en[0] == 1'b0, "R3 before expiry", int'(clk_en[0]), 0);
    @(negedge clk);
    chk(clk_en[0] == 1'b1, "R4 at expiry", int'(clk_en[0]), 1);
    // R3 restart after one low cycle
    pg = 1'b0;
    @(negedge clk);
    pg = 1'b1;
    chk(clk_en[0] == 1'b0, "R3 restart", int'(clk_en[0]), 0);
    repeat (SETTLE - 1) @(negedge clk);
    chk(clk_en[0] == 1'b0, "R3 restart before expiry", int'(clk_en[0]), 0);
    @(negedge clk);
    chk(clk_en[0] == 1'b1, "R3 restart expiry", int'(clk_en[0]), 1);

    // R2 R5 R6 R7 R11: sweep every config value from both enable states
    for (int s = 0; s < N; s++)
      for (int st = 0; st < 2; st++)
        for (int v = 0; v < (1 << CW); v++) begin
          wr(s, int'(m_cfg[s]), st[0]);
          check_state("R7 R2 same-cfg write", 1'b1);
          wr(s, v, v[0]);
          check_state(st ? "R6 R11 write while enabled" : "R5 R11 write while disabled", 1'b1);
        end

    // clear error flags via reset, converters off
    rst_n = 1'b0;
    for (int s = 0; s < N; s++) begin
      m_cfg[s] = '0; m_en[s] = 1'b0; m_err[s] = 1'b0;
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (SETTLE + 4) @(negedge clk);
    check_state("R1 second reset", 1'b1);

    // R8 gated converter: ack, no output, counted
    in_v[1] = 1'b1; in_d[DW +: DW] = 8'h3C; out_r[1] = 1'b0;
    #1;
    chk(in_r[1] == 1'b1 && out_v[1] == 1'b0, "R8 gated ack", int'({in_r[1], out_v[1]}), 2);
    @(negedge clk);
    in_v[1] = 1'b0;
    chk(int'(cnt[NW +: NW]) == 1, "R8 drop count", int'(cnt[NW +: NW]), 1);

    // collision: enable write and command in the same cycle
    in_v[1] = 1'b1; in_d[DW +: DW] = 8'h5A;
    wr(1, 0, 1'b1);
    chk(int'(cnt[NW +: NW]) == 2, "R8 same-cycle enable drop", int'(cnt[NW +: NW]), 2);
    // R9 passthrough now open
    for (int r = 0; r < 2; r++) begin
      out_r[1] = r[0]; in_d[DW +: DW] = 8'(8'hA0 + r);
      #1;
      chk(out_v[1] == 1'b1 && out_d[DW +: DW] == 8'(8'hA0 + r) && in_r[1] == r[0],
          "R9 passthrough", int'(out_d[DW +: DW]), 8'hA0 + r);
      @(negedge clk);
    end
    chk(int'(cnt[NW +: NW]) == 2, "R9 no count when open", int'(cnt[NW +: NW]), 2);
    in_v[1] = 1'b0;
    chk(int'(cnt[0 +: NW]) == 0, "R11 other counter", int'(cnt[0 +: NW]), 0);

    // R10 saturation
    wr(1, 0, 1'b0);
    in_v[1] = 1'b1;
    repeat (20) @(negedge clk);
    in_v[1] = 1'b0;
    chk(int'(cnt[NW +: NW]) == 15, "R10 saturate", int'(cnt[NW +: NW]), 15);

    report();
  end
endmodule